// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Multi-Cycle Multiply

This block is a small in-order instruction pipeline. Its stages are fetch, decode with register read, execute, and write-back. It runs a three-operation arithmetic set (add, subtract, multiply) plus a halt code over a four-entry, 16-bit register file. The program is a parameter of the block and is baked into an internal instruction array. The initial register contents are also a parameter, applied at reset. A one-cycle `start` pulse launches the program from address 0. The block raises `done` when the halt instruction leaves write-back.

Add and subtract spend one cycle in execute. Multiply stays there for three cycles. During that time the fetch and decode registers hold their contents and write-back receives empty slots. Results reach dependent instructions without waiting for the register file to update. A value can come from the instruction currently in write-back, or from the register write happening in the same cycle as the operand read.

Two counters are exposed: retired instructions and elapsed cycles. Any register can be read through a combinational debug select.

Top module: `pipe4_core`

## Requirements
- R1: After reset, `done` is 0, `retired` and `cycles` are 0, and each register holds its value from `REG_INIT` (register k in bits [16k+15:16k]). These values do not change until `start` is seen.
- R2: Instruction encoding is as follows. Bits [15:14] are the opcode: 00 add, 01 subtract, 10 multiply, 11 halt. Bits [13:12] are the destination, [11:10] the first source and [9:8] the second source. Bits [7:0] are ignored. The destination receives (a+b), (a−b) or the low 16 bits of a×b, all modulo 2^16.
- R3: A source register written by an older instruction still in the pipeline yields that instruction's result. No stall cycle is added for such a dependency.
- R4: If two older in-flight instructions both write the register a source names, the younger one's result is used.
- R5: Multiply holds execute for three cycles while fetch and decode hold, so each multiply adds exactly two cycles. A program of n instructions (halt included) with m multiplies finishes in n + 3 + 2m cycles.
- R6: When halt leaves write-back, `done` rises. `cycles` shows the total count (fetch of the first instruction is cycle 1) and `retired` shows n. All three then stay constant.
- R7: A `start` pulse while the program is running has no effect on its results or its counts.
- R8: A `start` pulse after `done` clears the counters and `done` and reruns from address 0. The register contents left by the previous run are kept.
- R9: `dbg_data` combinationally shows the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| dbg_sel | input | 2 | Register index for debug read |
| done | output | 1 | Set when halt retires, cleared by the next launch |
| retired | output | CNT_W | Instructions retired in this run, halt included |
| cycles | output | CNT_W | Cycles elapsed in this run |
| dbg_data | output | 16 | Contents of the selected register |

## Verification
Errors in forwarding or in the multiply hold do not halt the pipeline. They corrupt the destination registers. A wrong forward path or producer priority shows up as a wrong register value at the debug port once `done` rises, and a miscounted multiply hold can also show up there if the operands go stale. A hold that is one cycle too long or too short moves `cycles` away from n + 3 + 2m. A write-back that drops or repeats a slot moves `retired`. Because `done` depends only on the halt reaching write-back, every such fault is visible at the ports within a few cycles of the program's end.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

    localparam int DATA_W     = 16;
    localparam int REG_CNT    = 4;
    localparam int REG_AW     = $clog2(REG_CNT);
    localparam int INSTR_W    = 16;
    localparam int MUL_CYCLES = 3;
    localparam int MUL_CW     = $clog2(MUL_CYCLES + 1);
    localparam int SPARE_W    = INSTR_W - 2 - 3 * REG_AW;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_MUL  = 2'b10,
        OP_HALT = 2'b11
    } opcode_e;

    // Field order is fixed: the decoder relies on these positions.
    typedef struct packed {
        opcode_e             op;
        logic [REG_AW-1:0]   dst;
        logic [REG_AW-1:0]   src_a;
        logic [REG_AW-1:0]   src_b;
        logic [SPARE_W-1:0]  spare;
    } instr_t;

    typedef struct packed {
        logic   valid;
        instr_t word;
    } fetch_slot_t;

    typedef struct packed {
        logic              valid;
        opcode_e           op;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic [DATA_W-1:0] val_a;
        logic [DATA_W-1:0] val_b;
    } exec_slot_t;

    typedef struct packed {
        logic              valid;
        opcode_e           op;
        logic [REG_AW-1:0] dst;
        logic [DATA_W-1:0] result;
    } wb_slot_t;

    function automatic logic [DATA_W-1:0] alu_eval(opcode_e op,
                                                   logic [DATA_W-1:0] a,
                                                   logic [DATA_W-1:0] b);
        logic [2*DATA_W-1:0] prod;
        prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return prod[DATA_W-1:0];
            default: return '0;
        endcase
    endfunction

    function automatic logic writes_reg(opcode_e op);
        return op != OP_HALT;
    endfunction

endpackage

// File: rtl/pipe4_fetch.sv
module pipe4_fetch
    import pipe4_pkg::*;
#(
    parameter int PROG_LEN = 8,
    parameter logic [PROG_LEN*INSTR_W-1:0] PROGRAM = '1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        enable,
    output fetch_slot_t slot
);

    localparam int PC_W = $clog2(PROG_LEN + 1);

    logic [PC_W-1:0] pc;
    logic            halted;
    instr_t          word;

    // Addresses past the end of the array read as halt.
    always_comb begin
        if (pc < PC_W'(PROG_LEN))
            word = instr_t'(PROGRAM[pc*INSTR_W +: INSTR_W]);
        else
            word = instr_t'({INSTR_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pc     <= '0;
            halted <= 1'b0;
            slot   <= '0;
        end else if (enable) begin
            if (!halted) begin
                slot.valid <= 1'b1;
                slot.word  <= word;
                if (pc != PC_W'(PROG_LEN))
                    pc <= pc + 1'b1;
                if (word.op == OP_HALT)
                    halted <= 1'b1;
            end else begin
                slot.valid <= 1'b0;
            end
        end
    end

    // R5: the fetch address stays put while the front end is held
    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!enable && !clear) |=> $stable(pc));

endmodule

// File: rtl/pipe4_regfile.sv
module pipe4_regfile
    import pipe4_pkg::*;
#(
    parameter logic [REG_CNT*DATA_W-1:0] REG_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] rd_a_addr,
    input  logic [REG_AW-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [DATA_W-1:0] dbg_data
);

    logic [DATA_W-1:0]  regs [REG_CNT];
    logic [REG_CNT-1:0] wen;

    for (genvar g = 0; g < REG_CNT; g++) begin : g_wen
        assign wen[g] = we && (waddr == REG_AW'(g));
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < REG_CNT; k++) begin
            if (rst)
                regs[k] <= REG_INIT[k*DATA_W +: DATA_W];
            else if (wen[k])
                regs[k] <= wdata;
        end
    end

    // Same-cycle write-back bypass onto the decode read ports.
    assign rd_a_data = (we && waddr == rd_a_addr) ? wdata : regs[rd_a_addr];
    assign rd_b_data = (we && waddr == rd_b_addr) ? wdata : regs[rd_b_addr];
    assign dbg_data  = regs[dbg_sel];

    // R2: a write-back value lands in the addressed register
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe4_execute.sv
module pipe4_execute
    import pipe4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              run,
    input  fetch_slot_t       from_fetch,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [REG_AW-1:0] src_a_addr,
    output logic [REG_AW-1:0] src_b_addr,
    output wb_slot_t          to_wb,
    output logic              stall
);

    exec_slot_t        ex;
    logic [MUL_CW-1:0] mul_cnt;
    logic [DATA_W-1:0] fwd_a;
    logic [DATA_W-1:0] fwd_b;
    logic              hit_a;
    logic              hit_b;

    assign src_a_addr = from_fetch.word.src_a;
    assign src_b_addr = from_fetch.word.src_b;

    // The write-back slot is younger than anything captured at decode.
    assign hit_a = to_wb.valid && writes_reg(to_wb.op) && (to_wb.dst == ex.src_a);
    assign hit_b = to_wb.valid && writes_reg(to_wb.op) && (to_wb.dst == ex.src_b);
    assign fwd_a = hit_a ? to_wb.result : ex.val_a;
    assign fwd_b = hit_b ? to_wb.result : ex.val_b;

    assign stall = ex.valid && (ex.op == OP_MUL) &&
                   (mul_cnt != MUL_CW'(MUL_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ex      <= '0;
            to_wb   <= '0;
            mul_cnt <= '0;
        end else if (run) begin
            if (stall) begin
                mul_cnt     <= mul_cnt + 1'b1;
                ex.val_a    <= fwd_a;
                ex.val_b    <= fwd_b;
                to_wb.valid <= 1'b0;
            end else begin
                mul_cnt      <= '0;
                to_wb.valid  <= ex.valid;
                to_wb.op     <= ex.op;
                to_wb.dst    <= ex.dst;
                to_wb.result <= alu_eval(ex.op, fwd_a, fwd_b);
                ex.valid     <= from_fetch.valid;
                ex.op        <= from_fetch.word.op;
                ex.dst       <= from_fetch.word.dst;
                ex.src_a     <= from_fetch.word.src_a;
                ex.src_b     <= from_fetch.word.src_b;
                ex.val_a     <= opnd_a;
                ex.val_b     <= opnd_b;
            end
        end
    end

    // R5: a held multiply sends an empty slot to write-back
    assert_wb_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        (run && stall) |=> !to_wb.valid);

    // R5: the multiply stays in execute while held
    assert_mul_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (run && stall) |=> (ex.valid && $stable(ex.op) && $stable(ex.dst)));

    // R5: the hold counter never passes the multiply length
    assert_mul_range_R5: assert property (@(posedge clk) disable iff (rst)
        mul_cnt < MUL_CW'(MUL_CYCLES));

endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
    import pipe4_pkg::*;
#(
    parameter int PROG_LEN = 8,
    parameter logic [PROG_LEN*INSTR_W-1:0] PROGRAM = '1,
    parameter logic [REG_CNT*DATA_W-1:0]   REG_INIT = {16'd4, 16'd3, 16'd2, 16'd1},
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic              done,
    output logic [CNT_W-1:0]  retired,
    output logic [CNT_W-1:0]  cycles,
    output logic [DATA_W-1:0] dbg_data
);

    logic              running;
    logic              clear;
    logic              stall;
    logic              rf_we;
    logic              halt_retires;
    fetch_slot_t       f_slot;
    wb_slot_t          wb;
    logic [REG_AW-1:0] src_a_addr;
    logic [REG_AW-1:0] src_b_addr;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;

    assign clear        = start && !running;
    assign rf_we        = running && wb.valid && writes_reg(wb.op);
    assign halt_retires = running && wb.valid && (wb.op == OP_HALT);

    pipe4_fetch #(
        .PROG_LEN (PROG_LEN),
        .PROGRAM  (PROGRAM)
    ) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .enable (running && !stall),
        .slot   (f_slot)
    );

    pipe4_regfile #(
        .REG_INIT (REG_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (rf_we),
        .waddr     (wb.dst),
        .wdata     (wb.result),
        .rd_a_addr (src_a_addr),
        .rd_b_addr (src_b_addr),
        .rd_a_data (opnd_a),
        .rd_b_data (opnd_b),
        .dbg_sel   (dbg_sel),
        .dbg_data  (dbg_data)
    );

    pipe4_execute u_exec (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .run        (running),
        .from_fetch (f_slot),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .src_a_addr (src_a_addr),
        .src_b_addr (src_b_addr),
        .to_wb      (wb),
        .stall      (stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            done    <= 1'b0;
            retired <= '0;
            cycles  <= '0;
        end else if (clear) begin
            running <= 1'b1;
            done    <= 1'b0;
            retired <= '0;
            cycles  <= '0;
        end else if (running) begin
            cycles <= cycles + 1'b1;
            if (wb.valid)
                retired <= retired + 1'b1;
            if (halt_retires) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // R6: once finished, the cycle count is frozen until relaunch
    assert_cycles_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(cycles) && $stable(retired) && done);

    // R6: running and finished are never both set
    assert_run_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(running && done));

    // R6: at most one instruction retires per cycle
    assert_retire_step_R6: assert property (@(posedge clk) disable iff (rst)
        running |=> (retired == $past(retired) || retired == $past(retired) + 1'b1));

    // R7: a launch pulse during a run does not clear the counters
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (running && start && !halt_retires) |=> (running && cycles == $past(cycles) + 1'b1));

endmodule

// File: tb/pipe4_core_test.sv
module pipe4_core_test;

    function automatic logic [15:0] enc(int op, int d, int a, int b);
        return {op[1:0], d[1:0], a[1:0], b[1:0], 8'h00};
    endfunction

    localparam int PLEN = 10;
    localparam logic [PLEN*16-1:0] PROG = {
        enc(3, 0, 0, 0),   // I9 halt
        enc(0, 1, 0, 0),   // I8 R1 = R0 + R0   (R0 from two producers)
        enc(1, 0, 3, 0),   // I7 R0 = R3 - R0
        enc(0, 0, 0, 0),   // I6 R0 = R0 + R0
        enc(2, 3, 2, 0),   // I5 R3 = R2 * R0   (back-to-back multiply)
        enc(2, 2, 3, 3),   // I4 R2 = R3 * R3   (product wraps)
        enc(0, 0, 2, 1),   // I3 R0 = R2 + R1
        enc(1, 3, 3, 2),   // I2 R3 = R3 - R2
        enc(0, 2, 1, 2),   // I1 R2 = R1 + R2
        enc(2, 1, 0, 1)    // I0 R1 = R0 * R1
    };
    localparam logic [63:0] INIT = {16'd11, 16'd7, 16'd5, 16'd3};

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  dbg_sel;
    logic        done;
    logic [15:0] retired;
    logic [15:0] cycles;
    logic [15:0] dbg_data;

    int total = 0;
    int bad   = 0;
    logic [15:0] mreg [4];
    int exp_n;
    int exp_m;

    always #10 clk = ~clk;   // 20 ns period

    pipe4_core #(
        .PROG_LEN (PLEN),
        .PROGRAM  (PROG),
        .REG_INIT (INIT),
        .CNT_W    (16)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dbg_sel  (dbg_sel),
        .done     (done),
        .retired  (retired),
        .cycles   (cycles),
        .dbg_data (dbg_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] read_reg(int k);
        return 16'h0;
    endfunction

    task automatic peek(int k, output logic [15:0] v);
        dbg_sel = k[1:0];
        #1;
        v = dbg_data;
    endtask

    // Sequential instruction-set model: one instruction at a time.
    task automatic model_run();
        exp_n = 0;
        exp_m = 0;
        for (int k = 0; k < PLEN; k++) begin
            logic [15:0] w;
            logic [15:0] a;
            logic [15:0] b;
            logic [31:0] p;
            w = PROG[k*16 +: 16];
            exp_n++;
            if (w[15:14] == 2'b11) break;
            a = mreg[w[11:10]];
            b = mreg[w[9:8]];
            p = {16'h0, a} * {16'h0, b};
            case (w[15:14])
                2'b00: mreg[w[13:12]] = a + b;
                2'b01: mreg[w[13:12]] = a - b;
                default: begin
                    mreg[w[13:12]] = p[15:0];
                    exp_m++;
                end
            endcase
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " watchdog"}, {31'h0, done}, 32'h1);
    endtask

    task automatic check_regs(string tag);
        logic [15:0] v;
        for (int k = 0; k < 4; k++) begin
            peek(k, v);
            chk(tag, {16'h0, v}, {16'h0, mreg[k]});
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start = 1'b0;
        dbg_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", {31'h0, done}, 32'h0);
        chk("R1 retired after reset", {16'h0, retired}, 32'h0);
        chk("R1 cycles after reset", {16'h0, cycles}, 32'h0);
        for (int k = 0; k < 4; k++) mreg[k] = INIT[k*16 +: 16];
        check_regs("R1 R9 init register");
    endtask

    task automatic t_idle();
        repeat (8) @(negedge clk);
        chk("R1 idle cycles", {16'h0, cycles}, 32'h0);
        chk("R1 idle done", {31'h0, done}, 32'h0);
        check_regs("R1 idle register");
    endtask

    task automatic t_first_run();
        logic [15:0] v;
        model_run();
        pulse_start();
        wait_done("R6 first run");
        chk("R3 R5 cycle count", {16'h0, cycles}, exp_n + 3 + 2 * exp_m);
        chk("R6 retired count", {16'h0, retired}, exp_n);
        check_regs("R2 R3 result register");
        peek(1, v);
        chk("R4 younger producer wins", {16'h0, v}, 32'h2266);
        peek(2, v);
        chk("R2 multiply low half", {16'h0, v}, 32'h0079);
    endtask

    task automatic t_frozen();
        logic [15:0] c0;
        logic [15:0] r0;
        c0 = cycles;
        r0 = retired;
        repeat (12) @(negedge clk);
        chk("R6 cycles frozen", {16'h0, cycles}, {16'h0, c0});
        chk("R6 retired frozen", {16'h0, retired}, {16'h0, r0});
        chk("R6 done held", {31'h0, done}, 32'h1);
    endtask

    task automatic t_rerun_with_stray_start();
        model_run();
        pulse_start();
        chk("R8 done cleared", {31'h0, done}, 32'h0);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R7 second run");
        chk("R7 cycles with stray start", {16'h0, cycles}, exp_n + 3 + 2 * exp_m);
        chk("R8 retired restarted", {16'h0, retired}, exp_n);
        check_regs("R8 registers carried over");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_first_run();
        t_frozen();
        t_rerun_with_stray_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule